// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block is a single-channel hardware breakpoint matcher. It watches a processor bus one cycle at a time. It raises a one-cycle break request when a valid bus cycle meets every condition programmed into it. The conditions are:

- an address, where each bit can be excluded from the comparison;
- which master owns the cycle (CPU or DMA controller);
- whether the cycle is an instruction fetch or a data access;
- the direction of the transfer;
- the operand size.

Software programs the conditions through a simple register port. That port has a write strobe, a 2-bit register select and a combinational read-back. A sticky flag records that a break has happened. Software clears it by writing 0 to it.

The bus side is observe-only. `bus_valid` marks the cycles to inspect. The block is a monitor and never stalls the bus, so it has no ready signal and exerts no back-pressure. Every cycle with `bus_valid` high is evaluated, and the break output responds on the next clock edge.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset, all four registers read as 0 and `brk_pulse` is 0. Register select values: 0 = break address, 1 = address mask, 2 = cycle condition, 3 = status (bit 0 is the sticky flag).
- R2: The cycle-condition register keeps only write-data bits 7:0. Read-data bits 31:8 of that register are always 0, whatever was written.
- R3: When the master field (condition bits 7:6) is 00, no bus cycle produces a break.
- R4: Master field 01 matches only CPU cycles (`bus_is_dma`=0). Master field 10 or 11 matches only DMA cycles (`bus_is_dma`=1).
- R5: A mask bit of 1 removes that address bit from the comparison. Every address bit whose mask bit is 0 must equal the break address.
- R6: The kind field (bits 5:4) is encoded as follows: 00 matches either kind, 01 matches fetches only (`bus_is_fetch`=1), and 1x matches data accesses only.
- R7: The direction field (bits 3:2) is encoded as follows: 00 matches either direction, 01 matches reads only (`bus_is_write`=0), and 1x matches writes only.
- R8: The size field (bits 1:0) is encoded as follows: 00 matches any size, 01 matches byte, 10 matches word and 11 matches longword. The `bus_size` input is encoded 0 = byte, 1 = word, 2 = longword.
- R9: A cycle with `bus_valid` low never produces a break.
- R10: A matching valid cycle makes `brk_pulse` high for exactly the following clock cycle. Back-to-back matching cycles give back-to-back pulses. The sticky flag is set at the same edge.
- R11: Writing the status register with bit 0 = 0 clears the sticky flag. Writing bit 0 = 1 leaves it unchanged. If a new match arrives at the same edge as a clear, the flag stays set.
- R12: A bus cycle is compared against the register values held before the edge that ends it. A register write at that same edge affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Observed bus cycle is valid |
| bus_addr | input | 32 | Observed bus address |
| bus_is_dma | input | 1 | 1 = DMA controller cycle, 0 = CPU cycle |
| bus_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_is_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| brk_pulse | output | 1 | One-cycle break request |

## Verification
The hardest situations to reach are the collisions at a single edge.

- **Clear against a new match:** a status write that clears the sticky flag coincides with a new matching cycle.
- **Condition write against an observed cycle:** a condition-register write coincides with the bus cycle it would newly enable.

The bench drives the register write and the bus cycle in the same half-period, so both land on one rising edge. It then reads the flag back, and checks the pulse on the next edge and on the one after.

Masking is exercised by choosing addresses that differ from the break address only inside masked bits, and then only outside them. The don't-care low bit of the master field is covered by programming both 10 and 11.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int FIELD_W = 2;
  localparam int COND_LIVE_W = 4 * FIELD_W;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MASK = 2'd1,
    SEL_COND = 2'd2,
    SEL_STAT = 2'd3
  } brk_sel_e;

  typedef struct packed {
    logic [FIELD_W-1:0] master;
    logic [FIELD_W-1:0] kind;
    logic [FIELD_W-1:0] dir;
    logic [FIELD_W-1:0] size;
  } brk_cond_t;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          match_evt,
  output logic [AW-1:0] brk_addr,
  output logic [AW-1:0] brk_mask,
  output brk_cond_t     cond,
  output logic          sticky
);
  localparam int PAD_W = AW - COND_LIVE_W;

  logic clr_req;
  assign clr_req = reg_we && (reg_sel == SEL_STAT) && !reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '0;
      brk_mask <= '0;
      cond     <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_ADDR: brk_addr <= reg_wdata;
        SEL_MASK: brk_mask <= reg_wdata;
        SEL_COND: cond     <= brk_cond_t'(reg_wdata[COND_LIVE_W-1:0]);
        default:  ;
      endcase
    end
  end

  // Set has priority over a clear arriving at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky <= 1'b0;
    else if (match_evt) sticky <= 1'b1;
    else if (clr_req)   sticky <= 1'b0;
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = brk_addr;
      SEL_MASK: reg_rdata = brk_mask;
      SEL_COND: reg_rdata = {{PAD_W{1'b0}}, cond};
      default:  reg_rdata = {{(AW-1){1'b0}}, sticky};
    endcase
  end

  p_cond_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_COND) |-> (reg_rdata[AW-1:COND_LIVE_W] == '0));

  p_clear_wins_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match_evt) |=> !sticky);

  p_match_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> sticky);
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] brk_addr,
  input  logic [AW-1:0] brk_mask,
  output logic          addr_hit
);
  logic [AW-1:0] bit_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = brk_mask[i] | ~(bus_addr[i] ^ brk_addr[i]);
  end

  assign addr_hit = &bit_ok;

  p_full_mask_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&brk_mask) |-> addr_hit);

  p_exact_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == brk_addr) |-> addr_hit);
endmodule

// File: rtl/brk_qualify.sv
module brk_qualify
  import brk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  brk_cond_t cond,
  input  logic      bus_is_dma,
  input  logic      bus_is_fetch,
  input  logic      bus_is_write,
  input  logic [1:0] bus_size,
  output logic      qual_ok
);
  logic master_ok, kind_ok, dir_ok, size_ok;

  always_comb begin
    unique case (cond.master)
      2'b00:   master_ok = 1'b0;
      2'b01:   master_ok = !bus_is_dma;
      default: master_ok = bus_is_dma;
    endcase

    unique case (cond.kind)
      2'b00:   kind_ok = 1'b1;
      2'b01:   kind_ok = bus_is_fetch;
      default: kind_ok = !bus_is_fetch;
    endcase

    unique case (cond.dir)
      2'b00:   dir_ok = 1'b1;
      2'b01:   dir_ok = !bus_is_write;
      default: dir_ok = bus_is_write;
    endcase

    if (cond.size == 2'b00) size_ok = 1'b1;
    else                    size_ok = (bus_size == (cond.size - 2'd1));
  end

  assign qual_ok = master_ok & kind_ok & dir_ok & size_ok;

  p_dma_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_ok && cond.master[1]) |-> bus_is_dma);

  p_cpu_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_ok && cond.master == 2'b01) |-> !bus_is_dma);

  p_off_no_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond.master == 2'b00) |-> !qual_ok);
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_is_dma,
  input  logic          bus_is_fetch,
  input  logic          bus_is_write,
  input  logic [1:0]    bus_size,
  output logic          brk_pulse
);
  logic [AW-1:0] brk_addr, brk_mask;
  brk_cond_t     cond;
  logic          sticky, addr_hit, qual_ok, hit;

  brk_regfile #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .match_evt(hit),
    .brk_addr(brk_addr), .brk_mask(brk_mask), .cond(cond), .sticky(sticky)
  );

  brk_addr_cmp #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .brk_addr(brk_addr), .brk_mask(brk_mask),
    .addr_hit(addr_hit)
  );

  brk_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .cond(cond),
    .bus_is_dma(bus_is_dma), .bus_is_fetch(bus_is_fetch),
    .bus_is_write(bus_is_write), .bus_size(bus_size),
    .qual_ok(qual_ok)
  );

  assign hit = bus_valid & addr_hit & qual_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= hit;
  end

  p_pulse_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(bus_valid));

  p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> ($past(cond.master) != 2'b00));

  p_pulse_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> sticky);
endmodule

// File: tb/sim_bus_break_matcher.sv
module sim_bus_break_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_is_dma = 1'b0;
  logic        bus_is_fetch = 1'b0;
  logic        bus_is_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic        brk_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [31:0] BA = 32'h1000_0040;

  bus_break_matcher u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_is_dma(bus_is_dma), .bus_is_fetch(bus_is_fetch),
    .bus_is_write(bus_is_write), .bus_size(bus_size), .brk_pulse(brk_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic dma,
                       input logic f, input logic w, input logic [1:0] sz);
    bus_valid = v; bus_addr = a; bus_is_dma = dma;
    bus_is_fetch = f; bus_is_write = w; bus_size = sz;
  endtask

  // One observed cycle; returns brk_pulse one edge later.
  task automatic cyc(input logic v, input logic [31:0] a, input logic dma,
                     input logic f, input logic w, input logic [1:0] sz,
                     output logic got);
    @(negedge clk);
    drive(v, a, dma, f, w, sz);
    @(negedge clk);
    got = brk_pulse;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 reset pulse", {31'b0, brk_pulse}, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(2'd2, 32'hABCD_FF40);
    rd(2'd2, d);
    chk("R2 reserved bits", d, 32'h0000_0040);
  endtask

  task automatic t_disabled;
    logic g;
    wr(2'd0, BA); wr(2'd1, 32'h0); wr(2'd2, 32'h00);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R3 off cpu", {31'b0, g}, 0);
    cyc(1, BA, 1, 0, 0, 2, g); chk("R3 off dma", {31'b0, g}, 0);
  endtask

  task automatic t_master;
    logic g;
    wr(2'd2, 32'h40);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R4 01 cpu", {31'b0, g}, 1);
    cyc(1, BA, 1, 0, 0, 2, g); chk("R4 01 dma", {31'b0, g}, 0);
    wr(2'd2, 32'h80);
    cyc(1, BA, 1, 0, 0, 2, g); chk("R4 10 dma", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R4 10 cpu", {31'b0, g}, 0);
    wr(2'd2, 32'hC0);
    cyc(1, BA, 1, 0, 0, 2, g); chk("R4 11 dma", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R4 11 cpu", {31'b0, g}, 0);
  endtask

  task automatic t_mask;
    logic g;
    wr(2'd2, 32'h40);
    wr(2'd1, 32'h0000_00FF);
    cyc(1, 32'h1000_00AB, 0, 0, 0, 2, g); chk("R5 masked diff", {31'b0, g}, 1);
    cyc(1, 32'h1000_0140, 0, 0, 0, 2, g); chk("R5 unmasked diff", {31'b0, g}, 0);
    wr(2'd1, 32'h0);
    cyc(1, 32'h1000_0041, 0, 0, 0, 2, g); chk("R5 no mask lsb", {31'b0, g}, 0);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R5 exact", {31'b0, g}, 1);
  endtask

  task automatic t_kind;
    logic g;
    wr(2'd2, 32'h50);
    cyc(1, BA, 0, 1, 0, 2, g); chk("R6 fetch-only fetch", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R6 fetch-only data", {31'b0, g}, 0);
    wr(2'd2, 32'h60);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R6 data-only data", {31'b0, g}, 1);
    cyc(1, BA, 0, 1, 0, 2, g); chk("R6 data-only fetch", {31'b0, g}, 0);
  endtask

  task automatic t_dir;
    logic g;
    wr(2'd2, 32'h44);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R7 read-only read", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 1, 2, g); chk("R7 read-only write", {31'b0, g}, 0);
    wr(2'd2, 32'h48);
    cyc(1, BA, 0, 0, 1, 2, g); chk("R7 write-only write", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R7 write-only read", {31'b0, g}, 0);
  endtask

  task automatic t_size;
    logic g;
    wr(2'd2, 32'h41);
    cyc(1, BA, 0, 0, 0, 0, g); chk("R8 byte byte", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 1, g); chk("R8 byte word", {31'b0, g}, 0);
    wr(2'd2, 32'h42);
    cyc(1, BA, 0, 0, 0, 1, g); chk("R8 word word", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R8 word long", {31'b0, g}, 0);
    wr(2'd2, 32'h43);
    cyc(1, BA, 0, 0, 0, 2, g); chk("R8 long long", {31'b0, g}, 1);
    cyc(1, BA, 0, 0, 0, 0, g); chk("R8 long byte", {31'b0, g}, 0);
  endtask

  task automatic t_valid;
    logic g;
    logic [31:0] d;
    wr(2'd2, 32'h40);
    wr(2'd3, 32'h0);
    cyc(0, BA, 0, 0, 0, 2, g); chk("R9 invalid cycle", {31'b0, g}, 0);
    rd(2'd3, d); chk("R9 sticky untouched", d, 0);
  endtask

  task automatic t_pulse;
    logic [31:0] d;
    wr(2'd3, 32'h0);
    @(negedge clk); drive(1, BA, 0, 0, 0, 2);
    @(negedge clk); chk("R10 pulse 1st", {31'b0, brk_pulse}, 1);
    @(negedge clk); chk("R10 pulse back-to-back", {31'b0, brk_pulse}, 1);
    bus_valid = 1'b0;
    @(negedge clk); chk("R10 pulse ends", {31'b0, brk_pulse}, 0);
    rd(2'd3, d); chk("R10 sticky set", d, 1);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R11 write 1 keeps", d, 1);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R11 write 0 clears", d, 0);
    wr(2'd3, 32'h0);
    @(negedge clk); drive(1, BA, 0, 0, 0, 2);
    @(negedge clk);
    bus_valid = 1'b0;
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h0;
    drive(1, BA, 0, 0, 0, 2);
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    rd(2'd3, d); chk("R11 set wins over clear", d, 1);
  endtask

  task automatic t_write_timing;
    wr(2'd2, 32'h00);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h40;
    drive(1, BA, 0, 0, 0, 2);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R12 old cond used", {31'b0, brk_pulse}, 0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R12 new cond next", {31'b0, brk_pulse}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_disabled();
    t_master();
    t_mask();
    t_kind();
    t_dir();
    t_size();
    t_valid();
    t_pulse();
    t_sticky();
    t_write_timing();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule